// File: doc/BRIEF.md
# PLL Frequency and Bus Clock Calculator

This block works out, in hertz, the frequency that the main PLL of the chip would produce, and from that the frequency of the peripheral bus clock. It takes the strap word, the PLL parameter word and the clock-select word as plain inputs. A one-cycle start strobe captures them. The block then decodes the multiplier for the selected chip variant, multiplies the reference frequency by it, and divides the result down to the bus clock. All integer divisions go through a single shared sequential divider.

Two chip variants are supported, and they pack the PLL parameter fields differently. The older variant can leave its PLL unprogrammed. In that case a strap-selected frequency table gives the output instead. Both variants honour an off bit and a bypass bit. A calculation also starts by itself when reset is released, so valid frequencies appear without a strobe. Software or a clock tree model reads the three frequency outputs when the done flag pulses.

Top module: `pll_freq_calc`

## Requirements
- R1: The reference frequency is selected from the captured strap word as follows. It is 25 000 000 Hz when strap bit 23 is set. Otherwise it is 48 000 000 Hz when strap bit 18 is set. Otherwise it is 24 000 000 Hz. Bit 23 wins when both bits are set.
- R2: When parameter bit 24 is set, the PLL and bus frequencies are both 0, in either variant.
- R3: In the older variant (variant = 0), the PLL is programmed when parameter bit 18 is set and bypass bit 20 is clear. In that case the PLL output is ref × (2 − od) × ((n + 2) / (d + 1)). Here n = bits 10:5, od = bit 4 and d = bits 3:0, and each division truncates.
- R4: When bypass bit 20 is set, the PLL output equals the reference frequency. This applies to a programmed older-variant PLL and to the newer variant.
- R5: In the older variant with bit 18 clear, strap bits 9:8 select the PLL output in MHz. The values are {384, 360, 336, 408} for codes 0 to 3 with a 24 or 48 MHz reference. With a 25 MHz reference they are {400, 375, 350, 425}.
- R6: In the newer variant (variant = 1) without bypass, the PLL output is ref × (((m + 1) / (n + 1)) / (p + 1)). Here p = bits 18:13, m = bits 12:5 and n = bits 4:0, with truncating division. The product is kept modulo 2^32.
- R7: The bus frequency is (pll / (k + 1)) / 2 in the older variant and (pll / (k + 1)) / 4 in the newer one. Here k is clock-select bits 25:23, and both divisions truncate.
- R8: done is high for exactly one cycle per calculation. ref_hz, pll_hz and bus_hz change only in the cycle where done is high.
- R9: Inputs are captured on the accepted start. A start strobe that arrives while a calculation is running is ignored, and so are input changes made without a strobe.
- R10: While reset is asserted, all outputs are 0. After reset is released, one calculation runs on the inputs present at that time without any start strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Capture the inputs and begin a calculation |
| variant | input | 1 | 0 = older parameter layout, 1 = newer layout |
| strap | input | 32 | Strap word (reference selection, table code) |
| pll_cfg | input | 32 | PLL parameter word |
| clk_sel | input | 32 | Clock-select word holding the bus divider field |
| ref_hz | output | 32 | Reference frequency in Hz |
| pll_hz | output | 32 | PLL output frequency in Hz |
| bus_hz | output | 32 | Peripheral bus frequency in Hz |
| done | output | 1 | One-cycle pulse when the outputs are updated |

## Verification
The vector table exercises each multiplier path in turn: the strap table with each reference and several codes, the programmed older PLL with od both 0 and 1, the newer formula, bypass, and off. Each case is chosen to separate confusable behaviours. The older-variant cases use nonzero divider fields so that the divide-by-2 cannot be mistaken for the divide-by-4. One newer-variant case truncates its inner quotient to zero. Another case overflows 32 bits, which shows the wrap-around product. A case with both reference straps set shows which one has priority. Directed sequences cover the automatic run after reset, the one-cycle done pulse, a second strobe during a running calculation, and input changes made without a strobe.

// File: rtl/pllcalc_pkg.sv
package pllcalc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIV_A,
        ST_DIV_B,
        ST_SCALE,
        ST_DIV_C,
        ST_FIN
    } calc_state_e;

    // Strap table of the older variant, in MHz
    function automatic logic [9:0] strap_mhz(input logic ref25, input logic [1:0] code);
        logic [9:0] v;
        case ({ref25, code})
            3'b000: v = 10'd384;
            3'b001: v = 10'd360;
            3'b010: v = 10'd336;
            3'b011: v = 10'd408;
            3'b100: v = 10'd400;
            3'b101: v = 10'd375;
            3'b110: v = 10'd350;
            default: v = 10'd425;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/pllcalc_ref_sel.sv
module pllcalc_ref_sel #(
    parameter int REG_W     = 32,
    parameter int HZ_W      = 32,
    parameter int REF25_BIT = 23,
    parameter int REF48_BIT = 18
) (
    input  logic [REG_W-1:0] strap,
    output logic [HZ_W-1:0]  ref_hz,
    output logic             is_25m
);
    localparam logic [HZ_W-1:0] F24 = HZ_W'(24_000_000);
    localparam logic [HZ_W-1:0] F25 = HZ_W'(25_000_000);
    localparam logic [HZ_W-1:0] F48 = HZ_W'(48_000_000);

    always_comb begin
        is_25m = strap[REF25_BIT];
        if (strap[REF25_BIT])      ref_hz = F25;
        else if (strap[REF48_BIT]) ref_hz = F48;
        else                       ref_hz = F24;
    end
endmodule

// File: rtl/pllcalc_operands.sv
module pllcalc_operands
    import pllcalc_pkg::*;
#(
    parameter int REG_W     = 32,
    parameter int HZ_W      = 32,
    parameter int OFF_BIT   = 24,
    parameter int BYP_BIT   = 20,
    parameter int PRG_BIT   = 18,
    parameter int SEL_LO    = 8
) (
    input  logic             variant,
    input  logic [REG_W-1:0] cfg,
    input  logic [REG_W-1:0] strap,
    input  logic             is_25m,
    output logic [HZ_W-1:0]  num_a,
    output logic [HZ_W-1:0]  den_a,
    output logic [HZ_W-1:0]  den_b,
    output logic             od,
    output logic             pll_off,
    output logic             bypass,
    output logic             use_table,
    output logic [HZ_W-1:0]  table_hz
);
    localparam logic [HZ_W-1:0] MEGA = HZ_W'(1_000_000);

    // older layout
    logic [5:0] o_n;
    logic [3:0] o_d;
    // newer layout
    logic [5:0] w_p;
    logic [7:0] w_m;
    logic [4:0] w_n;

    always_comb begin
        o_n = cfg[10:5];
        o_d = cfg[3:0];
        w_p = cfg[18:13];
        w_m = cfg[12:5];
        w_n = cfg[4:0];

        pll_off   = cfg[OFF_BIT];
        bypass    = cfg[BYP_BIT];
        use_table = !variant && !cfg[PRG_BIT];
        table_hz  = HZ_W'(strap_mhz(is_25m, strap[SEL_LO +: 2])) * MEGA;

        if (variant) begin
            num_a = HZ_W'(w_m) + HZ_W'(1);
            den_a = HZ_W'(w_n) + HZ_W'(1);
            den_b = HZ_W'(w_p) + HZ_W'(1);
            od    = 1'b0;
        end else begin
            num_a = HZ_W'(o_n) + HZ_W'(2);
            den_a = HZ_W'(o_d) + HZ_W'(1);
            den_b = HZ_W'(1);
            od    = cfg[4];
        end
    end
endmodule

// File: rtl/pllcalc_divider.sv
module pllcalc_divider #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quotient,
    output logic         valid
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic [W-1:0]  rem;
        logic [W-1:0]  quo;
        logic [CW-1:0] cnt;
        logic          valid;
    } div_regs_t;

    div_regs_t r_d, r_q;
    logic [W:0] trial;

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        trial     = {r_q.rem, r_q.quo[W-1]};
        if (go) begin
            r_d.rem = '0;
            r_d.quo = dividend;
            r_d.cnt = CW'(W);
        end else if (r_q.cnt != '0) begin
            if (trial >= {1'b0, divisor}) begin
                r_d.rem = W'(trial - {1'b0, divisor});
                r_d.quo = {r_q.quo[W-2:0], 1'b1};
            end else begin
                r_d.rem = trial[W-1:0];
                r_d.quo = {r_q.quo[W-2:0], 1'b0};
            end
            r_d.cnt   = r_q.cnt - CW'(1);
            r_d.valid = (r_q.cnt == CW'(1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign quotient = r_q.quo;
    assign valid    = r_q.valid;
endmodule

// File: rtl/pll_freq_calc.sv
module pll_freq_calc
    import pllcalc_pkg::*;
#(
    parameter int REG_W     = 32,
    parameter int HZ_W      = 32,
    parameter int OFF_BIT   = 24,
    parameter int BYP_BIT   = 20,
    parameter int PRG_BIT   = 18,
    parameter int SEL_LO    = 8,
    parameter int REF25_BIT = 23,
    parameter int REF48_BIT = 18,
    parameter int DIVSEL_LO = 23,
    parameter int DIVSEL_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             variant,
    input  logic [REG_W-1:0] strap,
    input  logic [REG_W-1:0] pll_cfg,
    input  logic [REG_W-1:0] clk_sel,
    output logic [HZ_W-1:0]  ref_hz,
    output logic [HZ_W-1:0]  pll_hz,
    output logic [HZ_W-1:0]  bus_hz,
    output logic             done
);
    typedef struct packed {
        calc_state_e      st;
        logic             kick;
        logic             variant;
        logic [REG_W-1:0] strap;
        logic [REG_W-1:0] cfg;
        logic [REG_W-1:0] csel;
        logic [HZ_W-1:0]  quo;
        logic [HZ_W-1:0]  pll_w;
        logic [HZ_W-1:0]  ref_o;
        logic [HZ_W-1:0]  pll_o;
        logic [HZ_W-1:0]  bus_o;
        logic             go;
        logic             done;
    } calc_regs_t;

    calc_regs_t r_d, r_q;

    logic [HZ_W-1:0] ref_c, num_a, den_a, den_b, table_hz;
    logic            is_25m, od, pll_off, bypass, use_table;
    logic [HZ_W-1:0] div_num, div_den, div_q;
    logic            div_valid;
    logic [HZ_W-1:0] mult;

    pllcalc_ref_sel #(
        .REG_W(REG_W), .HZ_W(HZ_W), .REF25_BIT(REF25_BIT), .REF48_BIT(REF48_BIT)
    ) u_ref (
        .strap (r_q.strap),
        .ref_hz(ref_c),
        .is_25m(is_25m)
    );

    pllcalc_operands #(
        .REG_W(REG_W), .HZ_W(HZ_W), .OFF_BIT(OFF_BIT), .BYP_BIT(BYP_BIT),
        .PRG_BIT(PRG_BIT), .SEL_LO(SEL_LO)
    ) u_ops (
        .variant  (r_q.variant),
        .cfg      (r_q.cfg),
        .strap    (r_q.strap),
        .is_25m   (is_25m),
        .num_a    (num_a),
        .den_a    (den_a),
        .den_b    (den_b),
        .od       (od),
        .pll_off  (pll_off),
        .bypass   (bypass),
        .use_table(use_table),
        .table_hz (table_hz)
    );

    pllcalc_divider #(.W(HZ_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (r_q.go),
        .dividend(div_num),
        .divisor (div_den),
        .quotient(div_q),
        .valid   (div_valid)
    );

    always_comb begin
        case (r_q.st)
            ST_DIV_A: begin div_num = num_a;   div_den = den_a; end
            ST_DIV_B: begin div_num = r_q.quo; div_den = den_b; end
            default:  begin
                div_num = r_q.pll_w;
                div_den = HZ_W'(r_q.csel[DIVSEL_LO +: DIVSEL_W]) + HZ_W'(1);
            end
        endcase

        if (bypass)
            mult = HZ_W'(1);
        else if (!r_q.variant && !od)
            mult = {r_q.quo[HZ_W-2:0], 1'b0};
        else
            mult = r_q.quo;
    end

    always_comb begin
        r_d      = r_q;
        r_d.go   = 1'b0;
        r_d.done = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start || r_q.kick) begin
                    r_d.kick    = 1'b0;
                    r_d.variant = variant;
                    r_d.strap   = strap;
                    r_d.cfg     = pll_cfg;
                    r_d.csel    = clk_sel;
                    r_d.go      = 1'b1;
                    r_d.st      = ST_DIV_A;
                end
            end
            ST_DIV_A: begin
                if (div_valid) begin
                    r_d.quo = div_q;
                    r_d.go  = 1'b1;
                    r_d.st  = ST_DIV_B;
                end
            end
            ST_DIV_B: begin
                if (div_valid) begin
                    r_d.quo = div_q;
                    r_d.st  = ST_SCALE;
                end
            end
            ST_SCALE: begin
                if (pll_off)        r_d.pll_w = '0;
                else if (use_table) r_d.pll_w = table_hz;
                else                r_d.pll_w = ref_c * mult;
                r_d.go = 1'b1;
                r_d.st = ST_DIV_C;
            end
            ST_DIV_C: begin
                if (div_valid) begin
                    r_d.quo = div_q;
                    r_d.st  = ST_FIN;
                end
            end
            default: begin
                r_d.ref_o = ref_c;
                r_d.pll_o = r_q.pll_w;
                r_d.bus_o = r_q.variant ? (r_q.quo >> 2) : (r_q.quo >> 1);
                r_d.done  = 1'b1;
                r_d.st    = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.kick <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign ref_hz = r_q.ref_o;
    assign pll_hz = r_q.pll_o;
    assign bus_hz = r_q.bus_o;
    assign done   = r_q.done;

    logic             calc_busy;
    logic             cap_off;
    logic [REG_W-1:0] cap_cfg;
    assign calc_busy = (r_q.st != ST_IDLE);
    assign cap_off   = r_q.cfg[OFF_BIT];
    assign cap_cfg   = r_q.cfg;
endmodule

// File: rtl/pll_freq_calc_chk.sv
module pll_freq_calc_chk #(
    parameter int REG_W = 32,
    parameter int HZ_W  = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             done,
    input logic [HZ_W-1:0]  ref_hz,
    input logic [HZ_W-1:0]  pll_hz,
    input logic [HZ_W-1:0]  bus_hz,
    input logic             calc_busy,
    input logic             cap_off,
    input logic [REG_W-1:0] cap_cfg
);
    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(ref_hz) && $stable(pll_hz) && $stable(bus_hz)));

    // R1
    ref_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ref_hz == HZ_W'(24_000_000) || ref_hz == HZ_W'(25_000_000)
                  || ref_hz == HZ_W'(48_000_000)));

    // R2
    off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cap_off) |-> (pll_hz == '0 && bus_hz == '0));

    // R7
    bus_below_pll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (bus_hz <= (pll_hz >> 1)));

    // R9
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (calc_busy && start) |=> $stable(cap_cfg));
endmodule

bind pll_freq_calc pll_freq_calc_chk #(.REG_W(REG_W), .HZ_W(HZ_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .done     (done),
    .ref_hz   (ref_hz),
    .pll_hz   (pll_hz),
    .bus_hz   (bus_hz),
    .calc_busy(calc_busy),
    .cap_off  (cap_off),
    .cap_cfg  (cap_cfg)
);

// File: tb/test_pll_freq_calc.sv
`timescale 1ns/1ps
module test_pll_freq_calc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        variant = 1'b0;
    logic [31:0] strap = '0, pll_cfg = '0, clk_sel = '0;
    logic [31:0] ref_hz, pll_hz, bus_hz;
    logic        done;

    int compared = 0;
    int mismatched = 0;

    always #2 clk = ~clk;

    pll_freq_calc i_pll_freq_calc (
        .clk(clk), .rst_n(rst_n), .start(start), .variant(variant),
        .strap(strap), .pll_cfg(pll_cfg), .clk_sel(clk_sel),
        .ref_hz(ref_hz), .pll_hz(pll_hz), .bus_hz(bus_hz), .done(done)
    );

    typedef struct packed {
        logic        var_sel;
        logic [31:0] strap;
        logic [31:0] cfg;
        logic [31:0] csel;
        logic [31:0] e_ref;
        logic [31:0] e_pll;
        logic [31:0] e_bus;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'd24000000, 32'd384000000, 32'd192000000},  // R5
        '{1'b0, 32'h0080_0300, 32'h0000_0000, 32'h0080_0000, 32'd25000000, 32'd425000000, 32'd106250000},  // R5
        '{1'b0, 32'h0004_0200, 32'h0000_0000, 32'h0000_0000, 32'd48000000, 32'd336000000, 32'd168000000},  // R5
        '{1'b0, 32'h0000_0000, 32'h0004_03C3, 32'h0380_0000, 32'd24000000, 32'd384000000, 32'd24000000},   // R3
        '{1'b0, 32'h0080_0000, 32'h0004_0152, 32'h0180_0000, 32'd25000000, 32'd100000000, 32'd12500000},   // R3
        '{1'b0, 32'h0004_0000, 32'h0014_03C3, 32'h0000_0000, 32'd48000000, 32'd48000000,  32'd24000000},   // R4
        '{1'b0, 32'h0000_0000, 32'h0100_0000, 32'h0000_0000, 32'd24000000, 32'd0,         32'd0},          // R2
        '{1'b1, 32'h0000_0000, 32'h0000_23E1, 32'h0000_0000, 32'd24000000, 32'd192000000, 32'd48000000},   // R6
        '{1'b1, 32'h0080_0000, 32'h0000_1FE0, 32'h0200_0000, 32'd25000000, 32'd2105032704, 32'd105251635}, // R6
        '{1'b1, 32'h0004_0000, 32'h0010_23E1, 32'h0080_0000, 32'd48000000, 32'd48000000,  32'd6000000},    // R4
        '{1'b1, 32'h0000_0000, 32'h0100_1FE0, 32'h0000_0000, 32'd24000000, 32'd0,         32'd0},          // R2
        '{1'b1, 32'h0000_0000, 32'h0000_2082, 32'h0000_0000, 32'd24000000, 32'd0,         32'd0},          // R6
        '{1'b0, 32'h0084_0100, 32'h0000_0000, 32'h0000_0000, 32'd25000000, 32'd375000000, 32'd187500000}   // R1
    };

    function automatic string pll_tag(input int i);
        case (i)
            0, 1, 2:  return "R5";
            3, 4:     return "R3";
            5, 9:     return "R4";
            6, 10:    return "R2";
            7, 8, 11: return "R6";
            default:  return "R1";
        endcase
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    task automatic apply(input vec_t v, input logic strobe);
        @(negedge clk);
        variant = v.var_sel;
        strap   = v.strap;
        pll_cfg = v.cfg;
        clk_sel = v.csel;
        start   = strobe;
        @(negedge clk);
        start   = 1'b0;
    endtask

    // waits at negedges for done; returns 1 when seen
    task automatic wait_done(input int limit, output logic seen);
        seen = 1'b0;
        for (int c = 0; c < limit; c++) begin
            if (done) begin
                seen = 1'b1;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic check_vec(input vec_t v, input string ptag);
        check("R1", "ref_hz", ref_hz, v.e_ref);
        check(ptag, "pll_hz", pll_hz, v.e_pll);
        check("R7", "bus_hz", bus_hz, v.e_bus);
    endtask

    initial begin
        #400000;
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic seen;
        int   pulses;
        logic [31:0] h_ref, h_pll, h_bus;

        // R10: reset state
        variant = VECS[0].var_sel; strap = VECS[0].strap;
        pll_cfg = VECS[0].cfg;     clk_sel = VECS[0].csel;
        repeat (3) @(negedge clk);
        check("R10", "reset ref_hz", ref_hz, 32'd0);
        check("R10", "reset pll_hz", pll_hz, 32'd0);
        check("R10", "reset bus_hz", bus_hz, 32'd0);
        check("R10", "reset done", {31'd0, done}, 32'd0);
        rst_n = 1'b1;

        // R10: automatic calculation with no strobe
        wait_done(2000, seen);
        check("R10", "auto done", {31'd0, seen}, 32'd1);
        check_vec(VECS[0], "R10");
        // R8: single-cycle pulse
        @(negedge clk);
        check("R8", "done width", {31'd0, done}, 32'd0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            apply(VECS[i], 1'b1);
            wait_done(2000, seen);
            check(pll_tag(i), "done seen", {31'd0, seen}, 32'd1);
            check_vec(VECS[i], pll_tag(i));
        end

        // R9 / R8: input change without strobe leaves outputs alone
        h_ref = ref_hz; h_pll = pll_hz; h_bus = bus_hz;
        apply(VECS[7], 1'b0);
        pulses = 0;
        for (int c = 0; c < 300; c++) begin
            @(negedge clk);
            if (done) pulses++;
        end
        check("R9", "no-strobe pulses", pulses, 0);
        check("R9", "held ref_hz", ref_hz, h_ref);
        check("R8", "held pll_hz", pll_hz, h_pll);
        check("R9", "held bus_hz", bus_hz, h_bus);

        // R9: second strobe during a running calculation is ignored
        apply(VECS[3], 1'b1);
        repeat (4) @(negedge clk);
        apply(VECS[8], 1'b1);
        wait_done(2000, seen);
        check("R9", "busy done seen", {31'd0, seen}, 32'd1);
        check_vec(VECS[3], "R9");
        pulses = 0;
        for (int c = 0; c < 300; c++) begin
            @(negedge clk);
            if (done) pulses++;
        end
        check("R9", "extra pulses", pulses, 0);
        check("R9", "kept pll_hz", pll_hz, VECS[3].e_pll);

        finish_run();
    end
endmodule